// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This unit watches the occupancy of a dual-clock queue and drives two active-low warning flags. One goes low when the stored word count falls to a programmable distance from empty. The other goes low when the count climbs to within a programmable number of free words of full. The queue pointer logic sits outside the unit. It supplies the occupancy twice, once as a count valid in the write-clock domain and once as a count valid in the read-clock domain.

The two thresholds are held in offset registers. On master reset they take one of eight default values. After reset they can be rewritten one bit per write-clock edge through a serial input, or one word per write-clock edge from the offset data bus. On the read side they can be read back word by word. A mode input, latched at master reset, picks the flag timing. In single-clock mode each flag follows one domain's count only. In split-clock mode each flag is set from one domain and cleared only from the other. A partial reset restarts the flags and the load and read-back sequences but keeps both offsets.

Top module: `pflag_unit`

## Requirements
- R1: While `mrst` is high, the 3-bit code {`ld`,`fsel[1]`,`fsel[0]`} sets both offsets to 2^(code+2)-1 (code 0 gives 3, code 5 gives 127, code 7 gives 511). After reset `ae_n` is 0, `af_n` is 1 and `dout` is 0.
- R2: In single-clock mode, `ae_n` is 0 after a `rclk` edge at which `rd_count` <= almost-empty offset, and 1 otherwise.
- R3: In single-clock mode, `af_n` is 0 after a `wclk` edge at which `wr_count` + almost-full offset >= DEPTH, and 1 otherwise.
- R4: Each `wclk` edge with `wen` and `ld` high stores `din` into an offset. The first store after any reset goes to the almost-empty offset and the next to the almost-full offset, and the two alternate from then on.
- R5: Each `wclk` edge with `sen` and `ld` high, and `wen` low, shifts `si` into a 2*CW-bit chain. After 2*CW edges the almost-empty offset holds the first CW bits, least-significant bit first, and the almost-full offset holds the next CW bits.
- R6: Each `rclk` edge with `ren` and `ld` high puts an offset on `dout`, almost-empty first and then alternating. At any other edge `dout` keeps its value.
- R7: In split-clock mode, once `ae_n` is low it is raised only by a `wclk` edge at which `wr_count` > almost-empty offset. `rd_count` leaving the zone does not raise it.
- R8: In split-clock mode, once `af_n` is low it is raised only by a `rclk` edge at which `rd_count` + almost-full offset < DEPTH. `wr_count` leaving the zone does not raise it.
- R9: In single-clock mode `ae_n` ignores `wr_count` and `af_n` ignores `rd_count`.
- R10: `prst` keeps both offsets. It sets `ae_n` to 0 and `af_n` to 1, and restarts the write-store and read-back sequences at the almost-empty offset.
- R11: `pfm` (1 = split-clock, 0 = single-clock) is latched only during master reset. Changing it later has no effect.
- R12: A read-back on the same edge as a parallel store returns the offset value from before that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| pfm | input | 1 | Flag timing mode, latched at master reset (1 = split-clock) |
| fsel | input | 2 | Default offset select, low two bits of the code |
| ld | input | 1 | Offset access qualifier; top bit of the default code at reset |
| wen | input | 1 | Parallel store enable |
| sen | input | 1 | Serial shift enable |
| si | input | 1 | Serial offset bit |
| din | input | CW | Parallel offset word |
| ren | input | 1 | Read-back enable |
| wr_count | input | CW | Occupancy valid in the write domain |
| rd_count | input | CW | Occupancy valid in the read domain |
| dout | output | CW | Read-back offset word |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
A parallel store on the write side and a read-back on the read side can land on the same edge and touch the same offset register. The bench runs both clocks from one source. It raises `wen`, `ren` and `ld` together while both sequences point at the almost-empty offset. The result is judged by the word on `dout`, which must be the old value, and by later read-backs, which must show the new one. A second overlap occurs in split-clock mode, where a setting edge and a clearing edge share one clock instant. The bench moves the two counts apart and checks that only the permitted domain changes the flag.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

  // which offset register a load or read-back step addresses
  typedef enum logic {
    TGT_AE = 1'b0,
    TGT_AF = 1'b1
  } tgt_e;

  // reset-time default threshold for a 3-bit select code
  function automatic int unsigned dflt_offset(input logic [2:0] code);
    return (32'd1 << (32'(code) + 32'd2)) - 32'd1;
  endfunction

  function automatic tgt_e next_tgt(input tgt_e t);
    return (t == TGT_AE) ? TGT_AF : TGT_AE;
  endfunction

endpackage

// File: rtl/pflag_offsets.sv
module pflag_offsets #(
  parameter int CW = 12
) (
  input  logic          wclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          pfm,
  input  logic [1:0]    fsel,
  input  logic          ld,
  input  logic          wen,
  input  logic          sen,
  input  logic          si,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] ae_off,
  output logic [CW-1:0] af_off,
  output logic          mode_async
);
  import pflag_pkg::*;

  tgt_e          tgt;
  logic [2:0]    code;
  logic [CW-1:0] dflt;

  assign code = {ld, fsel};
  assign dflt = CW'(dflt_offset(code));

  always_ff @(posedge wclk) begin
    if (mrst) begin
      ae_off     <= dflt;
      af_off     <= dflt;
      mode_async <= pfm;
      tgt        <= TGT_AE;
    end else if (prst) begin
      tgt <= TGT_AE;
    end else if (wen && ld) begin
      if (tgt == TGT_AE) ae_off <= din;
      else               af_off <= din;
      tgt <= next_tgt(tgt);
    end else if (sen && ld) begin
      {af_off, ae_off} <= {si, af_off, ae_off[CW-1:1]};
    end
  end

endmodule

// File: rtl/pflag_readback.sv
module pflag_readback #(
  parameter int CW = 12
) (
  input  logic          rclk,
  input  logic          rst,
  input  logic          ren,
  input  logic          ld,
  input  logic [CW-1:0] ae_off,
  input  logic [CW-1:0] af_off,
  output logic [CW-1:0] dout
);
  import pflag_pkg::*;

  tgt_e rsel;

  always_ff @(posedge rclk) begin
    if (rst) begin
      dout <= '0;
      rsel <= TGT_AE;
    end else if (ren && ld) begin
      dout <= (rsel == TGT_AE) ? ae_off : af_off;
      rsel <= next_tgt(rsel);
    end
  end

endmodule

// File: rtl/pflag_flag.sv
module pflag_flag #(
  parameter bit RESET_ASSERTED = 1'b1
) (
  input  logic a_clk,
  input  logic r_clk,
  input  logic rst_a,
  input  logic rst_r,
  input  logic async_mode,
  input  logic trip_a,
  input  logic trip_r,
  output logic flag_n
);
  logic a_tog, r_tog, sync_n, asserted;

  assign asserted = a_tog ^ r_tog;

  // setting side: also owns the single-clock flag
  always_ff @(posedge a_clk) begin
    if (rst_a) begin
      a_tog  <= RESET_ASSERTED;
      sync_n <= ~RESET_ASSERTED;
    end else begin
      sync_n <= ~trip_a;
      if (async_mode && !asserted && trip_a) a_tog <= ~a_tog;
    end
  end

  // clearing side
  always_ff @(posedge r_clk) begin
    if (rst_r) r_tog <= 1'b0;
    else if (async_mode && asserted && !trip_r) r_tog <= ~r_tog;
  end

  assign flag_n = async_mode ? ~asserted : sync_n;

endmodule

// File: rtl/pflag_unit.sv
module pflag_unit #(
  parameter  int DEPTH = 2048,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          pfm,
  input  logic [1:0]    fsel,
  input  logic          ld,
  input  logic          wen,
  input  logic          sen,
  input  logic          si,
  input  logic [CW-1:0] din,
  input  logic          ren,
  input  logic [CW-1:0] wr_count,
  input  logic [CW-1:0] rd_count,
  output logic [CW-1:0] dout,
  output logic          ae_n,
  output logic          af_n
);
  localparam logic [CW:0] FULL = (CW+1)'(DEPTH);

  logic [CW-1:0] ae_off, af_off;
  logic          mode_async, any_rst;
  logic          ae_trip_rd, ae_trip_wr, af_trip_wr, af_trip_rd;

  assign any_rst = mrst | prst;

  pflag_offsets #(.CW(CW)) u_off (
    .wclk(wclk), .mrst(mrst), .prst(prst), .pfm(pfm), .fsel(fsel), .ld(ld),
    .wen(wen), .sen(sen), .si(si), .din(din),
    .ae_off(ae_off), .af_off(af_off), .mode_async(mode_async)
  );

  pflag_readback #(.CW(CW)) u_rb (
    .rclk(rclk), .rst(any_rst), .ren(ren), .ld(ld),
    .ae_off(ae_off), .af_off(af_off), .dout(dout)
  );

  assign ae_trip_rd = rd_count <= ae_off;
  assign ae_trip_wr = wr_count <= ae_off;
  assign af_trip_wr = ({1'b0, wr_count} + {1'b0, af_off}) >= FULL;
  assign af_trip_rd = ({1'b0, rd_count} + {1'b0, af_off}) >= FULL;

  pflag_flag #(.RESET_ASSERTED(1'b1)) u_ae (
    .a_clk(rclk), .r_clk(wclk), .rst_a(any_rst), .rst_r(any_rst),
    .async_mode(mode_async), .trip_a(ae_trip_rd), .trip_r(ae_trip_wr),
    .flag_n(ae_n)
  );

  pflag_flag #(.RESET_ASSERTED(1'b0)) u_af (
    .a_clk(wclk), .r_clk(rclk), .rst_a(any_rst), .rst_r(any_rst),
    .async_mode(mode_async), .trip_a(af_trip_wr), .trip_r(af_trip_rd),
    .flag_n(af_n)
  );

endmodule

// File: rtl/pflag_unit_chk.sv
module pflag_unit_chk #(
  parameter int DEPTH = 2048,
  parameter int CW    = 12
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst,
  input logic          prst,
  input logic          ren,
  input logic          ld,
  input logic [CW-1:0] wr_count,
  input logic [CW-1:0] rd_count,
  input logic [CW-1:0] ae_off,
  input logic [CW-1:0] af_off,
  input logic          mode_async,
  input logic [CW-1:0] dout,
  input logic          ae_n,
  input logic          af_n
);
  localparam logic [CW:0] FULL = (CW+1)'(DEPTH);

  AST_AE_SINGLE: assert property (@(posedge rclk) disable iff (mrst || prst)
    (!mode_async && !$past(mrst || prst)) |-> (ae_n == !($past(rd_count) <= $past(ae_off)))); // R2

  AST_AF_SINGLE: assert property (@(posedge wclk) disable iff (mrst || prst)
    (!mode_async && !$past(mrst || prst)) |->
      (af_n == !(({1'b0, $past(wr_count)} + {1'b0, $past(af_off)}) >= FULL))); // R3

  AST_RB_HOLD: assert property (@(posedge rclk) disable iff (mrst || prst)
    (!$past(mrst || prst) && !$past(ren && ld)) |-> $stable(dout)); // R6

  AST_AE_SPLIT_HOLD: assert property (@(posedge wclk) disable iff (mrst || prst)
    (mode_async && !$past(mrst || prst) && !$past(ae_n) && ($past(wr_count) <= $past(ae_off))) |-> !ae_n); // R7

  AST_AF_SPLIT_HOLD: assert property (@(posedge rclk) disable iff (mrst || prst)
    (mode_async && !$past(mrst || prst) && !$past(af_n) &&
     (({1'b0, $past(rd_count)} + {1'b0, $past(af_off)}) >= FULL)) |-> !af_n); // R8

  AST_PRST_KEEPS_OFFSETS: assert property (@(posedge wclk) disable iff (mrst)
    ($past(prst) && !$past(mrst)) |-> (ae_off == $past(ae_off) && af_off == $past(af_off))); // R10

  AST_MODE_LATCHED: assert property (@(posedge wclk) disable iff (mrst)
    !$past(mrst) |-> $stable(mode_async)); // R11

endmodule

bind pflag_unit pflag_unit_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .ren(ren), .ld(ld),
  .wr_count(wr_count), .rd_count(rd_count), .ae_off(ae_off), .af_off(af_off),
  .mode_async(mode_async), .dout(dout), .ae_n(ae_n), .af_n(af_n)
);

// File: tb/pflag_unit_bench.sv
module pflag_unit_bench;
  localparam int DEPTH = 2048;
  localparam int CW    = 12;

  logic          clk  = 1'b0;
  logic          mrst = 1'b1;
  logic          prst = 1'b0;
  logic          pfm  = 1'b0;
  logic [1:0]    fsel = '0;
  logic          ld   = 1'b0;
  logic          wen  = 1'b0;
  logic          sen  = 1'b0;
  logic          si   = 1'b0;
  logic [CW-1:0] din  = '0;
  logic          ren  = 1'b0;
  logic [CW-1:0] wr_count = '0;
  logic [CW-1:0] rd_count = '0;
  logic [CW-1:0] dout;
  logic          ae_n, af_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pflag_unit #(.DEPTH(DEPTH)) u_pflag_unit (
    .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .pfm(pfm), .fsel(fsel),
    .ld(ld), .wen(wen), .sen(sen), .si(si), .din(din), .ren(ren),
    .wr_count(wr_count), .rd_count(rd_count), .dout(dout), .ae_n(ae_n), .af_n(af_n)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mreset(input bit split, input logic [2:0] code);
    mrst = 1'b1; pfm = split; {ld, fsel} = code;
    wr_count = '0; rd_count = '0;
    tick(); tick();
    mrst = 1'b0; ld = 1'b0;
  endtask

  task automatic readback(output int val);
    ren = 1'b1; ld = 1'b1;
    tick();
    val = int'(dout);
    ren = 1'b0; ld = 1'b0;
  endtask

  task automatic pstore(input int val);
    wen = 1'b1; ld = 1'b1; din = CW'(val);
    tick();
    wen = 1'b0; ld = 1'b0;
  endtask

  task automatic counts(input int rd, input int wr);
    rd_count = CW'(rd); wr_count = CW'(wr);
    tick();
  endtask

  // R1: default table and reset state
  task automatic t_defaults();
    int v;
    logic [2:0] codes [3] = '{3'd0, 3'd5, 3'd7};
    foreach (codes[i]) begin
      mreset(1'b0, codes[i]);
      check("R1 ae_n reset", int'(ae_n), 0);
      check("R1 af_n reset", int'(af_n), 1);
      check("R1 dout reset", int'(dout), 0);
      readback(v); check("R1 ae default", v, (1 << (codes[i] + 2)) - 1);
      readback(v); check("R1 af default", v, (1 << (codes[i] + 2)) - 1);
    end
  endtask

  // R2 R3 R9: single-clock thresholds, each flag blind to the other count
  task automatic t_single();
    mreset(1'b0, 3'd0);
    counts(3, 0);    check("R2 ae at offset", int'(ae_n), 0);
    counts(4, 0);    check("R2 ae above offset", int'(ae_n), 1);
    counts(4, 0);    check("R9 ae ignores wr_count", int'(ae_n), 1);
    counts(0, 2045); check("R3 af at boundary", int'(af_n), 0);
    counts(0, 2044); check("R3 af below boundary", int'(af_n), 1);
    counts(2047, 100); check("R9 af ignores rd_count", int'(af_n), 1);
    check("R9 ae ignores wr_count high", int'(ae_n), 1);
  endtask

  // R4: parallel store order and use
  task automatic t_parallel();
    int v;
    mreset(1'b0, 3'd2);
    pstore(10); pstore(20);
    readback(v); check("R4 ae stored", v, 10);
    readback(v); check("R4 af stored", v, 20);
    counts(10, 0);   check("R4 ae uses stored", int'(ae_n), 0);
    counts(11, 0);   check("R4 ae above stored", int'(ae_n), 1);
    counts(0, 2028); check("R4 af uses stored", int'(af_n), 0);
    counts(0, 2027); check("R4 af below stored", int'(af_n), 1);
  endtask

  // R5: serial shift, almost-empty first, lsb first
  task automatic t_serial();
    int v;
    logic [2*CW-1:0] word;
    word = {CW'(291), CW'(90)};
    for (int i = 0; i < 2*CW; i++) begin
      sen = 1'b1; ld = 1'b1; si = word[i];
      tick();
    end
    sen = 1'b0; ld = 1'b0; si = 1'b0;
    readback(v); check("R5 ae serial", v, 90);
    readback(v); check("R5 af serial", v, 291);
  endtask

  // R10: partial reset keeps offsets, restarts sequences
  task automatic t_partial();
    int v;
    pstore(50);
    counts(500, 0);
    prst = 1'b1; tick(); prst = 1'b0;
    check("R10 ae_n after prst", int'(ae_n), 0);
    check("R10 af_n after prst", int'(af_n), 1);
    readback(v); check("R10 ae kept", v, 50);
    pstore(60);
    readback(v); check("R10 af kept", v, 291);
    readback(v); check("R10 store restarted at ae", v, 60);
  endtask

  // R7 R8 R11: split-clock timing
  task automatic t_split();
    mreset(1'b1, 3'd0);
    counts(10, 2);   check("R7 rd side cannot release ae", int'(ae_n), 0);
    counts(10, 10);  check("R7 wr side releases ae", int'(ae_n), 1);
    counts(2, 2);    check("R7 rd side asserts ae", int'(ae_n), 0);
    counts(2045, 2045); check("R8 wr side asserts af", int'(af_n), 0);
    counts(2045, 0); check("R8 wr side cannot release af", int'(af_n), 0);
    counts(0, 0);    check("R8 rd side releases af", int'(af_n), 1);
    check("R7 ae reasserted", int'(ae_n), 0);
    pfm = 1'b0;
    counts(10, 2);   check("R11 late pfm change ignored", int'(ae_n), 0);
    pfm = 1'b1;
  endtask

  // R12: parallel store and read-back on one edge
  task automatic t_collide();
    int v;
    mreset(1'b0, 3'd0);
    wen = 1'b1; ren = 1'b1; ld = 1'b1; din = CW'(77);
    tick();
    wen = 1'b0; ren = 1'b0; ld = 1'b0;
    check("R12 read-back sees old ae", int'(dout), 3);
    readback(v); check("R12 af untouched", v, 3);
    readback(v); check("R12 ae now new", v, 77);
  endtask

  initial begin
    tick(); tick();
    t_defaults();
    t_single();
    t_parallel();
    t_serial();
    t_partial();
    t_split();
    t_collide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule